// File: doc/BRIEF.md
# Bit-Reversed Pulse Counter

This block counts clock cycles in which its count input is high and shows the running total in bit-reversed form. After reset it shows 0. Each counted cycle moves it one step along the order 0, 4, 2, 6, 1, 5, 3, 7, and from 7 it returns to 0. The shown value is the natural binary count with its three bits read in reverse order.

The three state flip-flops drive the output pins directly, with no logic between them. This suits a consumer that wants a reversed-bit index, such as a stride-interleaving address source, with no translation stage after the register.

The next state can come from either of two sources. One is a set of per-bit toggle equations. The other is a behavioural form that reverses the count, increments it and reverses it back. A parameter chooses which source drives the register, and both are built so that they can be compared.

Top module: `revseq_pulse_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0, and it becomes 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: On a rising edge where `w` is 0, `count` keeps its value.
- R3: On a rising edge where `w` is 1, `count` moves one step along the order 0, 4, 2, 6, 1, 5, 3, 7.
- R4: On an advance from 7, `count` becomes 0.
- R5: On every advance, `count[2]` inverts.
- R6: On every advance, the new `count[1]` equals the old `count[1]` XOR the old `count[2]`.
- R7: On every advance, the new `count[0]` equals the old `count[0]` XOR (the old `count[1]` AND the old `count[2]`).
- R8: `count` always equals the bit-reversal of the number of advances since reset, taken modulo 8.
- R9: The equation form (`USE_EQUATIONS`=1) and the behavioural form (`USE_EQUATIONS`=0) give the same `count` for every input history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| w | input | 1 | Count enable, sampled on each rising edge |
| count | output | 3 | Bit-reversed count, driven directly by the state flip-flops |

## Verification
A directed run of long stretches of 1s walks through the order twice. This separates a correct bit-reversed step from a plain binary increment and shows the return from 7 to 0. Isolated 0s between 1s show whether a held cycle leaks into the count. A long random pattern of `w` is then checked against a model that reverses a binary counter, with both parameter forms run side by side. An asynchronous reset in the middle of the run, with no clock edge after it, shows whether the reset waits for the clock.

// File: rtl/revseq_pulse_counter.sv
module revseq_pulse_counter #(
  parameter bit USE_EQUATIONS = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       w,
  output logic [2:0] count
);

  logic [2:0] state_q;
  logic [2:0] eq_next;
  logic [2:0] beh_next;
  logic [2:0] nxt;
  logic [2:0] binary_now;
  logic [2:0] binary_inc;

  assign eq_next = w ? {~state_q[2], state_q[1] ^ state_q[2], state_q[0] ^ (state_q[1] & state_q[2])}
                     : state_q;

  assign binary_now = {state_q[0], state_q[1], state_q[2]};
  assign binary_inc = binary_now + 3'd1;
  assign beh_next   = w ? {binary_inc[0], binary_inc[1], binary_inc[2]} : state_q;

  generate
    if (USE_EQUATIONS) begin : g_eq
      assign nxt = eq_next;
    end else begin : g_beh
      assign nxt = beh_next;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 3'd0;
    else        state_q <= nxt;
  end

  assign count = state_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !w |=> $stable(count)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (w && count == 3'd7) |=> count == 3'd0); // R4
  AST_MSB_FLIP: assert property (@(posedge clk) disable iff (!rst_n) w |=> count[2] != $past(count[2])); // R5
  AST_MID_BIT: assert property (@(posedge clk) disable iff (!rst_n) w |=> count[1] == ($past(count[1]) ^ $past(count[2]))); // R6
  AST_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n) w |=> count[0] == ($past(count[0]) ^ ($past(count[1]) & $past(count[2])))); // R7
  AST_FORMS_AGREE: assert property (@(posedge clk) disable iff (!rst_n) eq_next == beh_next); // R9

endmodule

// File: tb/revseq_pulse_counter_test.sv
module revseq_pulse_counter_test;

  typedef struct {
    logic [2:0] expv;
    logic [2:0] prev;
    logic       adv;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       w = 1'b0;
  logic [2:0] count;
  logic [2:0] count_beh;

  int errors = 0;
  int checks = 0;
  logic [2:0] model_bin = 3'd0;
  item_t q[$];

  always #4 clk = ~clk;

  revseq_pulse_counter #(.USE_EQUATIONS(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .w(w), .count(count));

  revseq_pulse_counter #(.USE_EQUATIONS(1'b0)) uut_beh (
    .clk(clk), .rst_n(rst_n), .w(w), .count(count_beh));

  function automatic logic [2:0] rev3(input logic [2:0] v);
    return {v[0], v[1], v[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic drive(input logic v);
    item_t it;
    @(negedge clk);
    w = v;
    it.prev = rev3(model_bin);
    it.adv  = v;
    if (v) model_bin = model_bin + 3'd1;
    it.expv = rev3(model_bin);
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    string tag;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (!it.adv) tag = "R2";
        else if (it.prev == 3'd7) tag = "R4";
        else tag = "R3";
        chk(count == it.expv, tag, count, it.expv);
        chk(count == it.expv, "R8", count, it.expv);
        chk(count_beh == count, "R9", count_beh, count);
        if (it.adv) begin
          chk(count[2] == ~it.prev[2], "R5", count[2], ~it.prev[2]);
          chk(count[1] == (it.prev[1] ^ it.prev[2]), "R6", count[1], it.prev[1] ^ it.prev[2]);
          chk(count[0] == (it.prev[0] ^ (it.prev[1] & it.prev[2])), "R7", count[0],
              it.prev[0] ^ (it.prev[1] & it.prev[2]));
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    chk(count == 3'd0, "R1", count, 0);
    chk(count_beh == 3'd0, "R1", count_beh, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 17; i++) drive(1'b1);
    drive(1'b0);
    drive(1'b0);
    for (int i = 0; i < 10; i++) begin
      drive(1'b1);
      drive(1'b0);
    end
    for (int i = 0; i < 200; i++) drive(1'($urandom_range(0, 1)));
    drive(1'b0);
    @(posedge clk);
    #3;

    @(negedge clk);
    #1;
    rst_n = 1'b0;
    model_bin = 3'd0;
    #1;
    chk(count == 3'd0, "R1", count, 0);
    chk(count_beh == 3'd0, "R1", count_beh, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 100; i++) drive(1'($urandom_range(0, 1)));
    for (int i = 0; i < 9; i++) drive(1'b1);
    drive(1'b0);
    @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule